// File: doc/BRIEF.md
# I2C Master Byte and Condition Sequencer

This block is a bus-master engine for a two-wire serial bus. Software gives it one operation at a time: a START, a repeated START, a STOP, or one byte to transmit. The engine then drives the clock and data lines through open-drain pad controls and reports back. A control word selects the operation. A data write launches a byte transfer. A status word shows a busy flag while the engine works and a done flag once it has finished. After each byte the engine captures the acknowledge level from the target, and the control readback returns it.

The line timing is built from a parameterised tick divider. Every bus step, which is one change of one line, lasts `CLK_DIV` system clocks. Each operation is a fixed number of steps: a START takes 2, a repeated START 4, a STOP 3 and a byte 27 (nine bits of three steps each). The outputs `scl_oe` and `sda_oe` pull their line low when they are 1 and release it when they are 0. The engine never drives a line high. The sampled data line comes back in through `sda_in`.

Top module: `i2c_cmd_sequencer`

## Requirements
- R1: After reset both pad enables are 0 (lines released), `status` reads 0x00 and `ctrl_rd` reads 0x00.
- R2: A control write stores `wr_byte[0]` as enable and `wr_byte[2:1]` as the command (0 = no action, 1 = START/repeated START, 2 = STOP), and these read back on `ctrl_rd[2:0]`. An operation is launched only when the written enable bit is 1. A data write while the stored enable is 0 launches nothing.
- R3: A control write of command 1 with `wr_byte[3]` = 0 pulls SDA low while SCL is high, then pulls SCL low, and completes 2·CLK_DIV cycles after the write edge.
- R4: A control write of command 1 with `wr_byte[3]` = 1 releases SDA while SCL is low, then releases SCL, then pulls SDA low while SCL is high, then pulls SCL low, and completes 4·CLK_DIV cycles after the write edge.
- R5: Command 2 pulls SDA low while SCL is low, releases SCL, then releases SDA while SCL is high, and completes 3·CLK_DIV cycles after the write edge.
- R6: A data write, accepted only while the engine holds SCL low (after a START), shifts the byte out MSB first over eight SCL pulses. A ninth pulse follows with SDA released. SDA changes only while SCL is low. The write completes 27·CLK_DIV cycles after the write edge.
- R7: `ctrl_rd[3]` returns the SDA level sampled in the ninth clock of the most recent byte (1 = NAK, 0 = ACK) and holds it until the next byte completes.
- R8: `status[7]` (busy) is 1 from the edge that accepts an operation until it completes. Control and data writes made while busy is 1 are ignored.
- R9: `status[3]` (done) is set at the edge where an operation completes. The next accepted control write, including a no-action write, or the next launched operation clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Control word write strobe |
| data_wr | input | 1 | Data byte write strobe |
| wr_byte | input | 8 | Write value for either register |
| ctrl_rd | output | 8 | Control readback: {0000, nak, command[1:0], enable} |
| status | output | 8 | Bit 7 busy, bit 3 done, others 0 |
| sda_in | input | 1 | Sampled level of the data line |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |

## Verification
Busy must show on the clock edge that accepts a write. The bench therefore samples it half a cycle after that edge. It then counts exactly N·CLK_DIV − 1 further cycles (N = 2, 4, 3 or 27) and expects busy still high, and one cycle later expects busy low with done high. A bus monitor samples the line levels on the falling system clock. It rebuilds each byte and its acknowledge bit from the SCL rising edges and counts START and STOP conditions. The bench compares all of this with values worked out from the byte that was written and from the target's acknowledge setting. It sweeps all 256 byte values with ACK and NAK alternating.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

    typedef enum logic [1:0] {
        OP_START  = 2'd0,
        OP_RSTART = 2'd1,
        OP_STOP   = 2'd2,
        OP_BYTE   = 2'd3
    } seq_op_e;

    localparam logic [1:0] CMD_NONE  = 2'd0;
    localparam logic [1:0] CMD_COND  = 2'd1;
    localparam logic [1:0] CMD_STOP  = 2'd2;

    localparam int unsigned BITS_PER_BYTE = 8;

    typedef struct packed {
        logic        busy;
        seq_op_e     op;
        logic [1:0]  step;
        logic [3:0]  bitn;
        logic [1:0]  ph;
        logic [7:0]  shreg;
        logic        scl_rel;
        logic        sda_rel;
        logic        nak;
        logic        done;
    } eng_state_t;

    typedef struct packed {
        logic       en;
        logic [1:0] cmd;
    } ctl_state_t;

endpackage

// File: rtl/i2c_seq_tick.sv
module i2c_seq_tick #(
    parameter int unsigned DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == LAST);
        cnt_d = cnt_q + 1'b1;
        if (restart || tick) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // Step period bounds the timing of R3..R6
    assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/i2c_seq_engine.sv
module i2c_seq_engine
    import i2c_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       launch,
    input  seq_op_e    launch_op,
    input  logic [7:0] launch_byte,
    input  logic       clr_done,
    input  logic       sda_in,
    output logic       busy,
    output logic       done,
    output logic       nak,
    output logic       scl_oe,
    output logic       sda_oe
);
    localparam logic [3:0] ACK_SLOT = 4'(BITS_PER_BYTE);

    eng_state_t q, n;
    logic       finish;

    always_comb begin
        n      = q;
        finish = 1'b0;
        if (clr_done) n.done = 1'b0;
        if (launch && !q.busy) begin
            n.busy  = 1'b1;
            n.op    = launch_op;
            n.step  = '0;
            n.bitn  = '0;
            n.ph    = '0;
            n.shreg = launch_byte;
            n.done  = 1'b0;
        end else if (q.busy && tick) begin
            n.step = q.step + 1'b1;
            unique case (q.op)
                OP_START: begin
                    if (q.step == 2'd0) n.sda_rel = 1'b0;
                    else begin
                        n.scl_rel = 1'b0;
                        finish    = 1'b1;
                    end
                end
                OP_RSTART: begin
                    unique case (q.step)
                        2'd0:    n.sda_rel = 1'b1;
                        2'd1:    n.scl_rel = 1'b1;
                        2'd2:    n.sda_rel = 1'b0;
                        default: begin
                            n.scl_rel = 1'b0;
                            finish    = 1'b1;
                        end
                    endcase
                end
                OP_STOP: begin
                    unique case (q.step)
                        2'd0:    n.sda_rel = 1'b0;
                        2'd1:    n.scl_rel = 1'b1;
                        default: begin
                            n.sda_rel = 1'b1;
                            finish    = 1'b1;
                        end
                    endcase
                end
                default: begin
                    unique case (q.ph)
                        2'd0: begin
                            n.sda_rel = (q.bitn == ACK_SLOT) ? 1'b1 : q.shreg[7];
                            n.ph      = 2'd1;
                        end
                        2'd1: begin
                            n.scl_rel = 1'b1;
                            n.ph      = 2'd2;
                        end
                        default: begin
                            n.scl_rel = 1'b0;
                            n.ph      = 2'd0;
                            if (q.bitn == ACK_SLOT) begin
                                n.nak  = sda_in;
                                finish = 1'b1;
                            end else begin
                                n.shreg = {q.shreg[6:0], 1'b0};
                                n.bitn  = q.bitn + 1'b1;
                            end
                        end
                    endcase
                end
            endcase
            if (finish) begin
                n.busy = 1'b0;
                n.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.op      <= OP_START;
            q.scl_rel <= 1'b1;
            q.sda_rel <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign busy   = q.busy;
    assign done   = q.done;
    assign nak    = q.nak;
    assign scl_oe = !q.scl_rel;
    assign sda_oe = !q.sda_rel;

    // R6: data line only moves while the clock line is low during a byte
    assert_sda_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.op == OP_BYTE && q.scl_rel && $past(q.scl_rel)) |-> $stable(q.sda_rel));

    // R3 / R4: a falling data line with the clock high is only a start condition
    assert_start_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(q.sda_rel) && q.scl_rel) |-> (q.op == OP_START || q.op == OP_RSTART));

    // R5: a rising data line with the clock high is only a stop condition
    assert_stop_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(q.sda_rel) && q.scl_rel) |-> (q.op == OP_STOP));

endmodule

// File: rtl/i2c_cmd_sequencer.sv
module i2c_cmd_sequencer
    import i2c_seq_pkg::*;
#(
    parameter int unsigned CLK_DIV = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic       data_wr,
    input  logic [7:0] wr_byte,
    output logic [7:0] ctrl_rd,
    output logic [7:0] status,
    input  logic       sda_in,
    output logic       scl_oe,
    output logic       sda_oe
);
    ctl_state_t c_q, c_d;

    logic    busy, done, nak, tick;
    logic    ctrl_ok, data_ok, launch, clr_done;
    seq_op_e launch_op;

    always_comb begin
        c_d       = c_q;
        launch    = 1'b0;
        launch_op = OP_BYTE;
        clr_done  = 1'b0;
        ctrl_ok   = ctrl_wr && !busy;
        data_ok   = data_wr && !ctrl_wr && !busy && c_q.en && scl_oe;
        if (ctrl_ok) begin
            c_d.en   = wr_byte[0];
            c_d.cmd  = wr_byte[2:1];
            clr_done = 1'b1;
            if (wr_byte[0]) begin
                if (wr_byte[2:1] == CMD_COND) begin
                    launch    = 1'b1;
                    launch_op = wr_byte[3] ? OP_RSTART : OP_START;
                end else if (wr_byte[2:1] == CMD_STOP) begin
                    launch    = 1'b1;
                    launch_op = OP_STOP;
                end
            end
        end else if (data_ok) begin
            launch    = 1'b1;
            launch_op = OP_BYTE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    i2c_seq_tick #(.DIV(CLK_DIV)) i_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (launch),
        .tick    (tick)
    );

    i2c_seq_engine i_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .launch      (launch),
        .launch_op   (launch_op),
        .launch_byte (wr_byte),
        .clr_done    (clr_done),
        .sda_in      (sda_in),
        .busy        (busy),
        .done        (done),
        .nak         (nak),
        .scl_oe      (scl_oe),
        .sda_oe      (sda_oe)
    );

    assign ctrl_rd = {4'b0000, nak, c_q.cmd, c_q.en};
    assign status  = {busy, 3'b000, done, 3'b000};

    // R8: a control write during busy leaves the stored fields untouched
    assert_ignore_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctrl_wr) |=> $stable(ctrl_rd[2:0]));

    // R8: busy only starts in response to a write strobe
    assert_busy_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ctrl_wr || data_wr));

    // R9: completion raises done in the same cycle busy drops
    assert_done_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> status[3]);

    // R7: the acknowledge readback changes only at the end of an operation
    assert_nak_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_rd[3]) |-> $fell(busy));

endmodule

// File: tb/test_i2c_cmd_sequencer.sv
module test_i2c_cmd_sequencer;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_wr = 1'b0;
    logic       data_wr = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic [7:0] ctrl_rd, status;
    logic       scl_oe, sda_oe, sda_in;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  finished = 0;

    // bus and target model
    bit   ack_mode = 0;
    bit   in_byte  = 0;
    int   falls = 0, rises = 0, starts = 0, stops = 0, viol = 0;
    int   fall_base = 0;
    logic [8:0] cap = '0;
    logic scl_lvl, sda_lvl, tgt_pull;
    logic scl_prev = 1'b1, sda_prev = 1'b1;

    assign tgt_pull = ack_mode && in_byte && ((falls - fall_base) == 8);
    assign scl_lvl  = !scl_oe;
    assign sda_lvl  = !(sda_oe || tgt_pull);
    assign sda_in   = sda_lvl;

    always #5 clk = ~clk;

    i2c_cmd_sequencer #(.CLK_DIV(DIV)) i_i2c_cmd_sequencer (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .data_wr(data_wr),
        .wr_byte(wr_byte), .ctrl_rd(ctrl_rd), .status(status),
        .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    always @(negedge clk) begin
        if (!scl_prev && scl_lvl) begin
            rises <= rises + 1;
            cap   <= {cap[7:0], sda_lvl};
        end
        if (scl_prev && !scl_lvl) falls <= falls + 1;
        if (scl_prev && scl_lvl && sda_prev && !sda_lvl) starts <= starts + 1;
        if (scl_prev && scl_lvl && !sda_prev && sda_lvl) stops <= stops + 1;
        if (in_byte && scl_prev && scl_lvl && (sda_prev != sda_lvl)) viol <= viol + 1;
        scl_prev <= scl_lvl;
        sda_prev <= sda_lvl;
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic pulse_write(input bit is_data, input logic [7:0] val);
        @(negedge clk); #1;
        if (is_data) data_wr = 1'b1; else ctrl_wr = 1'b1;
        wr_byte = val;
        @(negedge clk); #1;
        ctrl_wr = 1'b0;
        data_wr = 1'b0;
    endtask

    task automatic run_op(input bit is_data, input logic [7:0] val, input int steps,
                          input string tag, input bit inject);
        int rem;
        pulse_write(is_data, val);
        chk(status[7], 1, {tag, " busy after write"});
        rem = DIV * steps - 1;
        if (inject) begin
            ctrl_wr = 1'b1; wr_byte = 8'h05;
            @(negedge clk); #1;
            ctrl_wr = 1'b0; data_wr = 1'b1; wr_byte = 8'h00;
            @(negedge clk); #1;
            data_wr = 1'b0;
            rem = rem - 2;
        end
        repeat (rem) @(negedge clk);
        #1;
        chk(status[7], 1, {tag, " busy last cycle"});
        @(negedge clk); #1;
        chk(status, 8'h08, {tag, " done at completion"});
    endtask

    task automatic send_byte(input logic [7:0] val, input bit ack, input bit inject);
        int r0;
        r0        = rises;
        fall_base = falls;
        ack_mode  = ack;
        in_byte   = 1;
        run_op(1, val, 27, "R6 byte", inject);
        in_byte   = 0;
        #2;
        chk(rises - r0, 9, "R6 clock pulse count");
        chk(cap[8:1], val, "R6 shifted byte MSB first");
        chk(cap[0], !ack, "R6 ninth bit level");
        chk(ctrl_rd[3], !ack, "R7 nak readback");
        chk(viol, 0, "R6 SDA moved while SCL high");
    endtask

    initial begin
        int s0;
        repeat (4) @(negedge clk);
        #1;
        chk(status, 8'h00, "R1 status after reset");
        chk(ctrl_rd, 8'h00, "R1 ctrl readback after reset");
        chk({scl_oe, sda_oe}, 2'b00, "R1 lines released");
        rst_n = 1'b1;

        // start command with enable 0: stored, nothing launched
        pulse_write(0, 8'h02);
        chk(status[7], 0, "R2 disabled start not launched");
        chk(ctrl_rd, 8'h02, "R2 readback fields");
        pulse_write(1, 8'h55);
        chk(status[7], 0, "R2 data write while disabled ignored");
        repeat (3 * DIV) @(negedge clk);
        #1;
        chk({scl_oe, sda_oe}, 2'b00, "R2 lines idle while disabled");

        pulse_write(0, 8'h01);
        chk(ctrl_rd, 8'h01, "R2 enable no-action readback");
        chk(status, 8'h00, "R2 no-action leaves idle");
        pulse_write(1, 8'h99);
        chk(status[7], 0, "R6 data write on idle bus ignored");

        s0 = starts;
        run_op(0, 8'h03, 2, "R3 start", 0);
        #2;
        chk(starts - s0, 1, "R3 start condition seen");
        chk({scl_oe, sda_oe}, 2'b11, "R3 both lines held low");
        chk(ctrl_rd[2:0], 3'b011, "R2 readback after start");

        for (int b = 0; b < 256; b++) begin
            send_byte(8'(b), ((b ^ (b >> 3)) & 1) == 0, 0);
        end

        // R8: writes during busy ignored
        s0 = stops;
        send_byte(8'hC3, 1, 1);
        chk(ctrl_rd[2:0], 3'b011, "R8 ctrl write during busy ignored");
        repeat (4 * DIV) @(negedge clk);
        #1;
        chk(status, 8'h08, "R8 no operation launched after busy writes");
        chk(stops - s0, 0, "R8 no stop from ignored write");

        // R9: done cleared by no-action write
        pulse_write(0, 8'h01);
        chk(status, 8'h00, "R9 done cleared by no-action");

        s0 = starts;
        run_op(0, 8'h0B, 4, "R4 repeated start", 0);
        #2;
        chk(starts - s0, 1, "R4 repeated start condition seen");
        chk({scl_oe, sda_oe}, 2'b11, "R4 both lines held low");
        chk(ctrl_rd, 8'h03, "R7 nak kept across repeated start");

        send_byte(8'h6E, 0, 0);
        chk(ctrl_rd, 8'h0B, "R7 nak readback with fields");

        s0 = stops;
        run_op(0, 8'h05, 3, "R5 stop", 0);
        #2;
        chk(stops - s0, 1, "R5 stop condition seen");
        chk({scl_oe, sda_oe}, 2'b00, "R5 lines released");

        pulse_write(1, 8'hA5);
        chk(status, 8'h08, "R6 data after stop ignored");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R8 watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule